// File: doc/BRIEF.md
# Buffered Dual-Rail Serial Word Transmitter

This block sends 32-bit data words onto an avionics serial bus. The host writes each word as two 16-bit halves through a 16-bit data port, one active-low strobe per half. Completed words collect in an eight-entry buffer. When the host raises the transmit enable, the block sends every buffered word, oldest first, with no further host action. A falling enable empties the buffer.

Each bit goes out on two complementary return-to-zero logic outputs. These are meant to feed an external line driver. A continuously running bit clock is phase-aligned with the data. A ready flag reports an empty buffer.

The control settings are plain inputs: rate select, word length and parity enable. A separate gating input can force parity insertion. The rate select picks the number of master-clock cycles per bit. The default divisors give 100 kbps and 12.5 kbps from a 1 MHz master clock.

Top module: `avb_word_tx`

## Requirements
- R1: A falling edge on `load_lo_ni` captures `data_i` as bits 15:0 of the pending word. A falling edge on `load_hi_ni` takes `data_i` as bits 31:16 and commits the whole word to the buffer.
- R2: The buffer holds `DEPTH` (8) words. A commit made while the buffer is full is dropped, and the buffered words are unaffected.
- R3: While `tx_en_i` is high, buffered words are sent in commit order, least-significant bit first. No word starts while `tx_en_i` is low.
- R4: For each bit, `line_a_o` is high during the first half of the bit time when the bit is 1, and `line_b_o` is high during the first half when the bit is 0. Both outputs are low during the second half of every bit and whenever no word is being sent. The two outputs are never high together.
- R5: One bit lasts `FAST_DIV` master clocks when `slow_rate_i` is 0, and `SLOW_DIV` master clocks when it is 1. `bit_clk_o` runs at all times with that period. It is high for the first half of each bit, and a word's first bit starts on a rising edge of `bit_clk_o`.
- R6: Consecutive words sent back to back are separated by exactly `GAP_BITS` (4) bit times with both outputs low.
- R7: Parity insertion is on when `par_force_i` is 1, or when `par_force_i` is 0 and `par_en_i` is 1. When it is on, the last bit of the word is replaced by odd parity over all the bits before it. When it is off, the word is sent exactly as written.
- R8: With `short_word_i` at 0 a word is 32 bits long. With `short_word_i` at 1 it is 25 bits long: bits 24:0 are sent, and bit 24 is the parity position.
- R9: A high-to-low transition of `tx_en_i` empties the buffer and stops a word in flight at once. `ready_o` is high on the next cycle, and nothing is sent after a later re-enable unless new words are written.
- R10: `ready_o` is low while `rst_ni` is low. After reset, it is high exactly when the buffer is empty.
- R11: Reset with `rst_ni` low empties the buffer and stops transmission, so words written before reset are never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 16 | Host data port for word halves |
| load_lo_ni | input | 1 | Active-low strobe, low half capture |
| load_hi_ni | input | 1 | Active-low strobe, high half and commit |
| tx_en_i | input | 1 | Transmit enable; falling edge clears buffer |
| slow_rate_i | input | 1 | 1 selects the slow bit rate |
| short_word_i | input | 1 | 1 selects 25-bit words |
| par_en_i | input | 1 | Parity insertion enable |
| par_force_i | input | 1 | 1 forces parity insertion |
| line_a_o | output | 1 | RZ output, high for 1 bits |
| line_b_o | output | 1 | RZ output, high for 0 bits |
| bit_clk_o | output | 1 | Bit-rate clock, high in first half of bit |
| ready_o | output | 1 | Buffer empty |

## Verification
A strobe edge sampled at one clock edge changes the buffer after that edge. `ready_o` therefore falls one cycle after a word-2 strobe and rises one cycle after a falling enable. The bench checks each of these several cycles later, sampling on the falling clock edge.

Serial results are due only at bit boundaries. A word begins on the first `bit_clk_o` rise after enable, and its value is complete at the first null bit that follows it. The bench therefore decodes the two lines on every observed rising edge of `bit_clk_o`. It rebuilds each word with its length and the number of preceding null bits, and compares the result with values computed arithmetically from the written data and the configuration. The bench sweeps both rates, both word lengths and all three parity modes on shortened divisors.

// File: rtl/avb_tx_pkg.sv
package avb_tx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_GAP  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/avb_bit_timer.sv
module avb_bit_timer #(
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic bit_clk_o,
  output logic bit_end_o
);
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit, half;

  assign limit     = slow_i ? CNT_W'(SLOW_DIV - 1) : CNT_W'(FAST_DIV - 1);
  assign half      = slow_i ? CNT_W'(SLOW_DIV / 2) : CNT_W'(FAST_DIV / 2);
  assign bit_end_o = (cnt_q >= limit);
  assign bit_clk_o = (cnt_q < half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (bit_end_o) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/avb_half_loader.sv
module avb_half_loader #(
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] data_i,
  input  logic              load_lo_ni,
  input  logic              load_hi_ni,
  output logic [2*HALF_W-1:0] word_o,
  output logic              commit_o
);
  logic lo_q, hi_q;
  logic [HALF_W-1:0] low_half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q       <= 1'b1;
      hi_q       <= 1'b1;
      low_half_q <= '0;
    end else begin
      lo_q <= load_lo_ni;
      hi_q <= load_hi_ni;
      if (lo_q && !load_lo_ni) low_half_q <= data_i;
    end
  end

  assign commit_o = hi_q && !load_hi_ni;
  assign word_o   = {data_i, low_half_q};
endmodule

// File: rtl/avb_word_fifo.sv
module avb_word_fifo #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       push_i,
  input  logic [WORD_W-1:0]          data_i,
  input  logic                       pop_i,
  output logic [WORD_W-1:0]          head_o,
  output logic [$clog2(DEPTH+1)-1:0] fill_o
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [FILL_W-1:0] fill_q;
  logic do_push, do_pop;

  assign do_push = push_i && (fill_q != FILL_W'(DEPTH));
  assign do_pop  = pop_i && (fill_q != '0);
  assign head_o  = mem_q[rd_q];
  assign fill_o  = fill_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else if (clear_i) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      fill_q <= fill_q + 1'b1;
      else if (do_pop && !do_push) fill_q <= fill_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clear_i) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/avb_serializer.sv
module avb_serializer
  import avb_tx_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int SHORT_LEN = 25,
  parameter int GAP_BITS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_end_i,
  input  logic              bit_clk_i,
  input  logic              tx_en_i,
  input  logic              abort_i,
  input  logic              avail_i,
  input  logic [WORD_W-1:0] head_i,
  input  logic              short_i,
  input  logic              par_ins_i,
  output logic              pop_o,
  output logic              line_a_o,
  output logic              line_b_o
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam int GAP_W = $clog2(GAP_BITS + 1);

  tx_state_e         state_q;
  logic [WORD_W-1:0] sh_q, frame;
  logic [IDX_W-1:0]  idx_q, last_q, last_d;
  logic [GAP_W-1:0]  gap_q;
  logic              par, gap_done, start;

  assign last_d   = short_i ? IDX_W'(SHORT_LEN - 1) : IDX_W'(WORD_W - 1);
  assign gap_done = (gap_q == GAP_W'(GAP_BITS - 1));
  assign start    = bit_end_i && tx_en_i && avail_i && !abort_i &&
                    ((state_q == TX_IDLE) || ((state_q == TX_GAP) && gap_done));
  assign pop_o    = start;

  // odd parity over the bits below the parity position
  always_comb begin
    par = 1'b1;
    for (int i = 0; i < WORD_W - 1; i++)
      if (IDX_W'(i) < last_d) par = par ^ head_i[i];
    frame = head_i;
    for (int i = 0; i < WORD_W; i++)
      if (par_ins_i && (IDX_W'(i) == last_d)) frame[i] = par;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      gap_q   <= '0;
    end else if (abort_i) begin
      state_q <= TX_IDLE;
    end else if (bit_end_i) begin
      unique case (state_q)
        TX_IDLE: if (start) begin
          state_q <= TX_SEND;
          sh_q    <= frame;
          idx_q   <= '0;
          last_q  <= last_d;
        end
        TX_SEND: if (idx_q == last_q) begin
          state_q <= TX_GAP;
          gap_q   <= '0;
        end else begin
          sh_q  <= sh_q >> 1;
          idx_q <= idx_q + 1'b1;
        end
        TX_GAP: if (gap_done) begin
          if (start) begin
            state_q <= TX_SEND;
            sh_q    <= frame;
            idx_q   <= '0;
            last_q  <= last_d;
          end else begin
            state_q <= TX_IDLE;
          end
        end else begin
          gap_q <= gap_q + 1'b1;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign line_a_o = (state_q == TX_SEND) && bit_clk_i && sh_q[0];
  assign line_b_o = (state_q == TX_SEND) && bit_clk_i && !sh_q[0];
endmodule

// File: rtl/avb_word_tx.sv
module avb_word_tx #(
  parameter int WORD_W    = 32,
  parameter int DEPTH     = 8,
  parameter int FAST_DIV  = 10,
  parameter int SLOW_DIV  = 80,
  parameter int SHORT_LEN = 25,
  parameter int GAP_BITS  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WORD_W/2-1:0] data_i,
  input  logic                load_lo_ni,
  input  logic                load_hi_ni,
  input  logic                tx_en_i,
  input  logic                slow_rate_i,
  input  logic                short_word_i,
  input  logic                par_en_i,
  input  logic                par_force_i,
  output logic                line_a_o,
  output logic                line_b_o,
  output logic                bit_clk_o,
  output logic                ready_o
);
  localparam int HALF_W = WORD_W / 2;
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] new_word, head;
  logic [FILL_W-1:0] fifo_fill;
  logic commit, pop, bit_end, en_q, en_fall, live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      live_q <= 1'b0;
    end else begin
      en_q   <= tx_en_i;
      live_q <= 1'b1;
    end
  end

  assign en_fall = en_q && !tx_en_i;
  assign ready_o = live_q && (fifo_fill == '0);

  avb_bit_timer #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slow_i    (slow_rate_i),
    .bit_clk_o (bit_clk_o),
    .bit_end_o (bit_end)
  );

  avb_half_loader #(.HALF_W(HALF_W)) u_loader (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (data_i),
    .load_lo_ni (load_lo_ni),
    .load_hi_ni (load_hi_ni),
    .word_o     (new_word),
    .commit_o   (commit)
  );

  avb_word_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (en_fall),
    .push_i  (commit),
    .data_i  (new_word),
    .pop_i   (pop),
    .head_o  (head),
    .fill_o  (fifo_fill)
  );

  avb_serializer #(.WORD_W(WORD_W), .SHORT_LEN(SHORT_LEN), .GAP_BITS(GAP_BITS)) u_ser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_end_i (bit_end),
    .bit_clk_i (bit_clk_o),
    .tx_en_i   (tx_en_i),
    .abort_i   (en_fall),
    .avail_i   (fifo_fill != '0),
    .head_i    (head),
    .short_i   (short_word_i),
    .par_ins_i (par_force_i || par_en_i),
    .pop_o     (pop),
    .line_a_o  (line_a_o),
    .line_b_o  (line_b_o)
  );
endmodule

// File: rtl/avb_word_tx_chk.sv
module avb_word_tx_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       tx_en_i,
  input logic                       line_a_o,
  input logic                       line_b_o,
  input logic                       bit_clk_o,
  input logic                       ready_o,
  input logic [$clog2(DEPTH+1)-1:0] fill_i
);
  p_rails_exclusive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_a_o && line_b_o));

  p_return_to_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_clk_o |-> (!line_a_o && !line_b_o));

  p_a_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_a_o) |-> $rose(bit_clk_o));

  p_b_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_b_o) |-> $rose(bit_clk_o));

  p_fill_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= ($clog2(DEPTH+1))'(DEPTH));

  p_fall_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_en_i) |=> ready_o);
endmodule

bind avb_word_tx avb_word_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_en_i   (tx_en_i),
  .line_a_o  (line_a_o),
  .line_b_o  (line_b_o),
  .bit_clk_o (bit_clk_o),
  .ready_o   (ready_o),
  .fill_i    (fifo_fill)
);

// File: tb/avb_word_tx_bench.sv
module avb_word_tx_bench;
  localparam int FD = 4;
  localparam int SD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] data = '0;
  logic lo_n = 1'b1, hi_n = 1'b1, en = 1'b0;
  logic slow = 1'b0, shrt = 1'b0, pen = 1'b0, pforce = 1'b0;
  logic la, lb, bclk, rdy;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  avb_word_tx #(.FAST_DIV(FD), .SLOW_DIV(SD)) u_avb_word_tx (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .load_lo_ni(lo_n), .load_hi_ni(hi_n),
    .tx_en_i(en), .slow_rate_i(slow), .short_word_i(shrt), .par_en_i(pen),
    .par_force_i(pforce), .line_a_o(la), .line_b_o(lb), .bit_clk_o(bclk), .ready_o(rdy)
  );

  // line decoder
  logic [31:0] rx_word [16];
  int          rx_len  [16];
  int          rx_gap  [16];
  int          rx_n = 0, cur_len = 0, nulls = 99, rz_errs = 0;
  logic [31:0] cur_word = '0;
  logic        prev_bclk = 1'b0, flush = 1'b0;
  logic [31:0] wq [9];

  always @(negedge clk) begin
    if (rst_n && !flush) begin
      if (la && lb) rz_errs++;
      if ((la || lb) && !bclk) rz_errs++;
      if (bclk && !prev_bclk) begin
        if (la || lb) begin
          if (cur_len == 0 && rx_n < 16) rx_gap[rx_n] = nulls;
          if (cur_len < 32) cur_word[cur_len] = la;
          cur_len++;
        end else if (cur_len > 0) begin
          if (rx_n < 16) begin
            rx_word[rx_n] = cur_word;
            rx_len[rx_n]  = cur_len;
          end
          rx_n++;
          cur_len  = 0;
          cur_word = '0;
          nulls    = 1;
        end else begin
          nulls++;
        end
      end
    end
    prev_bclk = bclk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_word(input logic [31:0] w);
    data = w[15:0];  lo_n = 1'b0; cyc(2); lo_n = 1'b1; cyc(2);
    data = w[31:16]; hi_n = 1'b0; cyc(2); hi_n = 1'b1; cyc(2);
    data = 16'hDEAD;
  endtask

  task automatic clear_rx();
    flush = 1'b1; cyc(1);
    rx_n = 0; cur_len = 0; cur_word = '0; nulls = 99;
    flush = 1'b0;
  endtask

  task automatic wait_words(input int n);
    for (int t = 0; t < 20000 && rx_n < n; t++) cyc(1);
  endtask

  function automatic logic [31:0] exp_frame(input logic [31:0] raw, input bit s, input bit ins);
    int len;
    logic [31:0] m;
    logic p;
    len = s ? 25 : 32;
    m = raw;
    p = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i >= len) m[i] = 1'b0;
      if (i < len - 1) p = p ^ raw[i];
    end
    if (ins) m[len-1] = p;
    return m;
  endfunction

  task automatic measure_rate(input int div);
    int hi_c, tot;
    hi_c = 0; tot = 0;
    @(negedge clk); while (bclk) @(negedge clk);
    while (!bclk) @(negedge clk);
    while (bclk) begin hi_c++; @(negedge clk); end
    tot = hi_c;
    while (!bclk) begin tot++; @(negedge clk); end
    chk(hi_c == div / 2, "R5", "bit clock high time", hi_c, div / 2);
    chk(tot == div, "R5", "bit period", tot, div);
  endtask

  // block send across one configuration
  task automatic run_block(input int n, input bit s, input bit ins);
    int len;
    len = s ? 25 : 32;
    clear_rx();
    for (int k = 0; k < n; k++) write_word(wq[k]);
    chk(rdy == 1'b0, "R10", "ready low with words buffered", rdy, 0);
    cyc(3 * SD);
    chk(rx_n == 0, "R3", "nothing sent while disabled", rx_n, 0);
    en = 1'b1;
    wait_words(n);
    chk(rx_n == n, "R3", "word count", rx_n, n);
    for (int k = 0; k < n && k < rx_n; k++) begin
      chk(rx_word[k] == exp_frame(wq[k], s, ins), ins ? "R7" : "R1",
          "word value", rx_word[k], exp_frame(wq[k], s, ins));
      chk(rx_len[k] == len, "R8", "word length", rx_len[k], len);
      if (k > 0) chk(rx_gap[k] == 4, "R6", "gap bits", rx_gap[k], 4);
    end
    chk(rdy == 1'b1, "R10", "ready high after drain", rdy, 1);
    en = 1'b0;
    cyc(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk(rdy == 1'b0, "R10", "ready in reset", rdy, 0);
    chk({la, lb} == 2'b00, "R11", "lines in reset", {la, lb}, 0);
    rst_n = 1'b1;
    cyc(3);
    chk(rdy == 1'b1, "R10", "ready after reset", rdy, 1);

    for (int r = 0; r < 2; r++) begin
      slow = r[0];
      cyc(20);
      measure_rate(r[0] ? SD : FD);
    end

    // sweep rate x length x parity mode
    for (int c = 0; c < 12; c++) begin
      slow   = c[0];
      shrt   = c[1];
      pforce = (c / 4) == 2;
      pen    = (c / 4) == 1;
      wq[0] = 32'hA5C3_0F1E ^ (c * 32'h9E37_79B9);
      wq[1] = (c % 3 == 0) ? 32'hFFFF_FFFF : 32'h0000_0000;
      wq[2] = 32'h8000_0001 ^ (c * 32'h0101_0101);
      cyc(10);
      run_block(3, shrt, pforce | pen);
    end
    chk(rz_errs == 0, "R4", "dual-rail RZ violations", rz_errs, 0);

    // full buffer: ninth commit dropped
    slow = 1'b0; shrt = 1'b0; pen = 1'b0; pforce = 1'b0;
    for (int k = 0; k < 9; k++) wq[k] = 32'h1357_0000 + k * 32'h0011_2233;
    clear_rx();
    for (int k = 0; k < 9; k++) write_word(wq[k]);
    en = 1'b1;
    wait_words(8);
    cyc(60 * FD);
    chk(rx_n == 8, "R2", "words sent from full buffer", rx_n, 8);
    for (int k = 0; k < 8 && k < rx_n; k++)
      chk(rx_word[k] == wq[k], "R2", "kept word", rx_word[k], wq[k]);
    en = 1'b0;
    cyc(2);

    // falling enable mid-word
    clear_rx();
    wq[0] = 32'h0F0F_1234; wq[1] = 32'h5555_AAAA; wq[2] = 32'h0BAD_CAFE;
    for (int k = 0; k < 3; k++) write_word(wq[k]);
    en = 1'b1;
    wait_words(1);
    cyc(10 * FD);
    flush = 1'b1;
    en = 1'b0;
    cyc(2);
    chk(rdy == 1'b1, "R9", "ready after falling enable", rdy, 1);
    chk({la, lb} == 2'b00, "R9", "lines quiet after abort", {la, lb}, 0);
    clear_rx();
    en = 1'b1;
    cyc(100 * FD);
    chk(rx_n == 0 && cur_len == 0, "R9", "nothing sent after re-enable", rx_n + cur_len, 0);
    en = 1'b0;
    cyc(2);

    // reset drops buffered words
    clear_rx();
    write_word(32'h7777_1111);
    write_word(32'h2222_8888);
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(2);
    chk(rdy == 1'b1, "R11", "buffer empty after reset", rdy, 1);
    en = 1'b1;
    cyc(80 * FD);
    chk(rx_n == 0 && cur_len == 0, "R11", "no words after reset", rx_n + cur_len, 0);
    en = 1'b0;
    cyc(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule